// File: doc/BRIEF.md
# Fetch-Stage Branch Target Cache with Direction Counters

This block sits beside the instruction fetch address register and produces the address for the next fetch. Every cycle with a valid fetch address it looks up a small direct-mapped cache of branch targets. If that lookup hits and the entry's two-bit direction counter leans taken, the cached target becomes the next fetch address one cycle later, with no decode involved. Otherwise fetch falls through to the next aligned instruction group.

A cache line covers an aligned group of two 4-byte instructions. The index and tag come from address bits [3] and up. A taken branch in either slot of the group writes the line's target, so two branches in one group overwrite each other. The execute stage reports each resolved branch with its address, outcome, target and a mispredict flag. A mispredict sends fetch to the corrected address and overrides any prediction made in the same cycle. Lines carry no context identifier, so stale history can cost extra mispredicts but cannot cause wrong execution.

Top module: `btc_predictor`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `next_pc` is RESET_PC (0) and `pred_taken` and `redirect` are 0. Reset invalidates every cache line, so any fetch after reset misses.
- R2: A fetch that misses, or that is not predicted taken, sets `next_pc` to the start of the following 8-byte group one cycle later, with `pred_taken` 0. For example, 0x10C gives 0x110.
- R3: A fetch that hits a valid line with counter bit [1] set sets `next_pc` to the cached target one cycle later, with `pred_taken` 1.
- R4: A taken resolution that misses the cache allocates the line with the branch's tag and target, and sets its counter to weakly taken (10).
- R5: Both instruction addresses of an 8-byte group share one line. A taken resolution at either address replaces the target, and a fetch of either address sees it.
- R6: Counter codes are 11 strongly taken, 10 weakly taken, 01 weakly not taken and 00 strongly not taken. A resolution on a hit moves the counter one step toward its outcome and saturates at 00 and 11. Codes 10 and 11 predict taken, 01 and 00 predict not taken.
- R7: From strongly taken, one not-taken resolution still leaves the prediction taken. A second one reverses it.
- R8: A not-taken resolution on a hit moves only the counter. The line's valid bit, tag and target remain in place.
- R9: A not-taken resolution that misses changes no line.
- R10: `rslv_valid` with `rslv_mispredict` sets `next_pc` one cycle later to `rslv_target` if taken, or to `rslv_pc`+4 if not. It also sets `redirect` 1 and `pred_taken` 0, overriding a same-cycle fetch. `rslv_mispredict` without `rslv_valid` has no effect.
- R11: An allocation whose index matches a line with a different tag replaces that line. After that, the old address misses.
- R12: A cycle with no fetch and no mispredict leaves `next_pc` unchanged and drives `pred_taken` and `redirect` to 0.
- R13: A resolution write is not visible to a fetch lookup in the same cycle. That fetch uses the line's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | `fetch_pc` is a live fetch this cycle |
| fetch_pc | input | ADDR_W | Current fetch address |
| rslv_valid | input | 1 | A branch resolution is reported |
| rslv_pc | input | ADDR_W | Address of the resolved branch |
| rslv_taken | input | 1 | Resolved direction, 1 = taken |
| rslv_target | input | ADDR_W | Resolved taken target |
| rslv_mispredict | input | 1 | The branch was mispredicted |
| next_pc | output | ADDR_W | Registered next fetch address |
| pred_taken | output | 1 | `next_pc` came from a taken prediction |
| redirect | output | 1 | `next_pc` came from a mispredict correction |

## Verification
A counter in the wrong state shows up at `next_pc` on the next fetch of that group. The fetch returns either the cached target or the fall-through address, one cycle after the lookup. A wrong tag or target, or a wrongly kept or dropped line, appears the same way: as a hit where a miss was expected, or as the wrong target. The stimulus therefore interleaves resolutions with fetches of the same groups, so that each counter step and each line replacement is observed at `next_pc`. Errors in the mispredict override show up in the cycle right after the resolution, as a wrong `next_pc` or a wrong `redirect`.

// File: rtl/btc_pkg.sv
package btc_pkg;

  typedef enum logic [1:0] {
    CNT_SNT = 2'b00,
    CNT_WNT = 2'b01,
    CNT_WT  = 2'b10,
    CNT_ST  = 2'b11
  } cnt_t;

  typedef enum logic [1:0] {
    OP_INIT = 2'b00,
    OP_INC  = 2'b01,
    OP_DEC  = 2'b10
  } cnt_op_t;

  // Saturating step of a two-bit direction counter.
  function automatic cnt_t cnt_step(input cnt_t cur, input cnt_op_t op);
    cnt_t res;
    case (op)
      OP_INC:  res = (cur == CNT_ST)  ? CNT_ST  : cnt_t'(cur + 2'd1);
      OP_DEC:  res = (cur == CNT_SNT) ? CNT_SNT : cnt_t'(cur - 2'd1);
      default: res = CNT_WT;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/btc_tag_store.sv
module btc_tag_store #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 25,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd0_idx,
  output logic              rd0_valid,
  output logic [TAG_W-1:0]  rd0_tag,
  output logic [ADDR_W-1:0] rd0_tgt,
  input  logic [IDX_W-1:0]  rd1_idx,
  output logic              rd1_valid,
  output logic [TAG_W-1:0]  rd1_tag,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_tgt
);

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_mem [ENTRIES];
  logic [ADDR_W-1:0]  tgt_mem [ENTRIES];

  // Valid bits need a reset, so they live in flops; one per line.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_valid
    always_ff @(posedge clk) begin
      if (rst)
        valid_q[g] <= 1'b0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        valid_q[g] <= 1'b1;
    end
  end

  // Tag and target arrays: plain write port, no reset, RAM-friendly.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      tgt_mem[wr_idx] <= wr_tgt;
    end
  end

  assign rd0_valid = valid_q[rd0_idx];
  assign rd0_tag   = tag_mem[rd0_idx];
  assign rd0_tgt   = tgt_mem[rd0_idx];
  assign rd1_valid = valid_q[rd1_idx];
  assign rd1_tag   = tag_mem[rd1_idx];

  // R4
  alloc_valid_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_q[$past(wr_idx)]);

  // R4
  alloc_data_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (tag_mem[$past(wr_idx)] == $past(wr_tag)) && (tgt_mem[$past(wr_idx)] == $past(wr_tgt)));

endmodule

// File: rtl/btc_dir_counters.sv
module btc_dir_counters
  import btc_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  cnt_op_t          wr_op
);

  cnt_t cnt_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)
        cnt_q[g] <= CNT_WT;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        cnt_q[g] <= cnt_step(cnt_q[g], wr_op);
    end
  end

  assign rd_taken = cnt_q[rd_idx][1];

  // R6
  inc_leaves_snt_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_op == OP_INC) |=> cnt_q[$past(wr_idx)] != CNT_SNT);

  // R6
  dec_leaves_st_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_op == OP_DEC) |=> cnt_q[$past(wr_idx)] != CNT_ST);

  // R6
  top_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_op == OP_INC && cnt_q[wr_idx] == CNT_ST) |=> cnt_q[$past(wr_idx)] == CNT_ST);

  // R4
  init_weak_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_op == OP_INIT) |=> cnt_q[$past(wr_idx)] == CNT_WT);

endmodule

// File: rtl/btc_predictor.sv
module btc_predictor
  import btc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int ENTRIES     = 16,
  parameter int INSN_BYTES  = 4,
  parameter int GROUP_INSNS = 2,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              rslv_valid,
  input  logic [ADDR_W-1:0] rslv_pc,
  input  logic              rslv_taken,
  input  logic [ADDR_W-1:0] rslv_target,
  input  logic              rslv_mispredict,
  output logic [ADDR_W-1:0] next_pc,
  output logic              pred_taken,
  output logic              redirect
);

  localparam int GROUP_BYTES = INSN_BYTES * GROUP_INSNS;
  localparam int OFS_W       = $clog2(GROUP_BYTES);
  localparam int IDX_W       = $clog2(ENTRIES);
  localparam int TAG_W       = ADDR_W - OFS_W - IDX_W;

  // Fetch-side lookup
  logic [IDX_W-1:0]  f_idx, r_idx;
  logic [TAG_W-1:0]  f_tag, r_tag;
  logic              f_valid, r_valid, f_ctr_taken;
  logic [TAG_W-1:0]  f_line_tag, r_line_tag;
  logic [ADDR_W-1:0] f_line_tgt;
  logic              f_hit, r_hit, f_predict;
  logic [ADDR_W-1:0] fall_thru, corr_pc;

  // Resolution-side update
  logic              ts_wr_en, ct_wr_en, do_redirect;
  cnt_op_t           ct_op;

  assign f_idx = fetch_pc[OFS_W +: IDX_W];
  assign f_tag = fetch_pc[ADDR_W-1 -: TAG_W];
  assign r_idx = rslv_pc[OFS_W +: IDX_W];
  assign r_tag = rslv_pc[ADDR_W-1 -: TAG_W];

  btc_tag_store #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W),
    .ADDR_W  (ADDR_W)
  ) u_tags (
    .clk       (clk),
    .rst       (rst),
    .rd0_idx   (f_idx),
    .rd0_valid (f_valid),
    .rd0_tag   (f_line_tag),
    .rd0_tgt   (f_line_tgt),
    .rd1_idx   (r_idx),
    .rd1_valid (r_valid),
    .rd1_tag   (r_line_tag),
    .wr_en     (ts_wr_en),
    .wr_idx    (r_idx),
    .wr_tag    (r_tag),
    .wr_tgt    (rslv_target)
  );

  btc_dir_counters #(
    .ENTRIES (ENTRIES)
  ) u_ctrs (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (f_idx),
    .rd_taken (f_ctr_taken),
    .wr_en    (ct_wr_en),
    .wr_idx   (r_idx),
    .wr_op    (ct_op)
  );

  assign f_hit     = f_valid && (f_line_tag == f_tag);
  assign r_hit     = r_valid && (r_line_tag == r_tag);
  assign f_predict = f_hit && f_ctr_taken;

  // Start of the next aligned group: set the offset bits, then add one.
  assign fall_thru = (fetch_pc | ADDR_W'(GROUP_BYTES - 1)) + ADDR_W'(1);
  assign corr_pc   = rslv_taken ? rslv_target : (rslv_pc + ADDR_W'(INSN_BYTES));

  // Update policy: a hit steps the counter; a taken outcome writes the line;
  // a taken miss allocates with a fresh weakly-taken counter; a not-taken miss does nothing.
  always_comb begin
    ts_wr_en = rslv_valid && rslv_taken;
    ct_wr_en = rslv_valid && (r_hit || rslv_taken);
    if (!r_hit)
      ct_op = OP_INIT;
    else if (rslv_taken)
      ct_op = OP_INC;
    else
      ct_op = OP_DEC;
  end

  assign do_redirect = rslv_valid && rslv_mispredict;

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc    <= RESET_PC;
      pred_taken <= 1'b0;
      redirect   <= 1'b0;
    end else if (do_redirect) begin
      next_pc    <= corr_pc;
      pred_taken <= 1'b0;
      redirect   <= 1'b1;
    end else if (fetch_valid) begin
      next_pc    <= f_predict ? f_line_tgt : fall_thru;
      pred_taken <= f_predict;
      redirect   <= 1'b0;
    end else begin
      pred_taken <= 1'b0;
      redirect   <= 1'b0;
    end
  end

  // R10
  redirect_target_chk: assert property (@(posedge clk) disable iff (rst)
    (rslv_valid && rslv_mispredict) |=> redirect && !pred_taken &&
      (next_pc == ($past(rslv_taken) ? $past(rslv_target) : ($past(rslv_pc) + ADDR_W'(INSN_BYTES)))));

  // R10
  pred_redirect_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pred_taken, redirect}));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fetch_valid && !(rslv_valid && rslv_mispredict)) |=> $stable(next_pc) && !pred_taken && !redirect);

  // R2
  fall_thru_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !(rslv_valid && rslv_mispredict)) |=>
      pred_taken || (next_pc == (($past(fetch_pc) | ADDR_W'(GROUP_BYTES - 1)) + ADDR_W'(1))));

endmodule

// File: tb/tb_btc_predictor.sv
module tb_btc_predictor;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          fetch_valid;
  logic [AW-1:0] fetch_pc;
  logic          rslv_valid;
  logic [AW-1:0] rslv_pc;
  logic          rslv_taken;
  logic [AW-1:0] rslv_target;
  logic          rslv_mispredict;
  logic [AW-1:0] next_pc;
  logic          pred_taken;
  logic          redirect;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  btc_predictor dut (
    .clk             (clk),
    .rst             (rst),
    .fetch_valid     (fetch_valid),
    .fetch_pc        (fetch_pc),
    .rslv_valid      (rslv_valid),
    .rslv_pc         (rslv_pc),
    .rslv_taken      (rslv_taken),
    .rslv_target     (rslv_target),
    .rslv_mispredict (rslv_mispredict),
    .next_pc         (next_pc),
    .pred_taken      (pred_taken),
    .redirect        (redirect)
  );

  typedef struct packed {
    logic [7:0]    req;
    logic          fv;
    logic [AW-1:0] fpc;
    logic          rv;
    logic [AW-1:0] rpc;
    logic          rt;
    logic [AW-1:0] rtgt;
    logic          rm;
    logic [AW-1:0] enext;
    logic          epred;
    logic          eredir;
  } vec_t;

  localparam int NV = 23;
  // Line 0 holds groups 0x100 (tag 2), 0x200 (tag 4) and 0x300 (tag 6).
  localparam vec_t VEC [NV] = '{
    // R2: empty cache, fetch 0x100 falls through to 0x108
    '{8'd2,  1'b1, 32'h100, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h108, 1'b0, 1'b0},
    // R4/R12: taken branch at 0x104 allocates target 0x400, no fetch -> hold
    '{8'd12, 1'b0, 32'h0,   1'b1, 32'h104, 1'b1, 32'h400, 1'b0, 32'h108, 1'b0, 1'b0},
    // R3/R5: fetch 0x100 hits group line, weakly taken -> 0x400
    '{8'd3,  1'b1, 32'h100, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h400, 1'b1, 1'b0},
    // R13: taken at 0x100 rewrites target to 0x500; same-cycle fetch still sees 0x400
    '{8'd13, 1'b1, 32'h100, 1'b1, 32'h100, 1'b1, 32'h500, 1'b0, 32'h400, 1'b1, 1'b0},
    // R5: fetch 0x104 sees the overwritten target 0x500 (counter now 11)
    '{8'd5,  1'b1, 32'h104, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h500, 1'b1, 1'b0},
    // R7: one not-taken, 11 -> 10
    '{8'd7,  1'b0, 32'h0,   1'b1, 32'h100, 1'b0, 32'h0,   1'b0, 32'h500, 1'b0, 1'b0},
    // R7/R8: still predicted taken, target kept
    '{8'd7,  1'b1, 32'h100, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h500, 1'b1, 1'b0},
    // R7: second not-taken, 10 -> 01
    '{8'd7,  1'b0, 32'h0,   1'b1, 32'h100, 1'b0, 32'h0,   1'b0, 32'h500, 1'b0, 1'b0},
    // R7/R6: prediction reversed, falls through
    '{8'd7,  1'b1, 32'h100, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h108, 1'b0, 1'b0},
    // R6: 01 -> 00
    '{8'd6,  1'b0, 32'h0,   1'b1, 32'h100, 1'b0, 32'h0,   1'b0, 32'h108, 1'b0, 1'b0},
    // R6: 00 saturates
    '{8'd6,  1'b0, 32'h0,   1'b1, 32'h100, 1'b0, 32'h0,   1'b0, 32'h108, 1'b0, 1'b0},
    // R6: taken, 00 -> 01
    '{8'd6,  1'b0, 32'h0,   1'b1, 32'h100, 1'b1, 32'h500, 1'b0, 32'h108, 1'b0, 1'b0},
    // R6: 01 predicts not taken even on a hit
    '{8'd6,  1'b1, 32'h100, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h108, 1'b0, 1'b0},
    // R6: taken, 01 -> 10
    '{8'd6,  1'b0, 32'h0,   1'b1, 32'h100, 1'b1, 32'h500, 1'b0, 32'h108, 1'b0, 1'b0},
    // R8: target 0x500 survived the not-taken runs
    '{8'd8,  1'b1, 32'h104, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h500, 1'b1, 1'b0},
    // R10/R9: not-taken mispredict at 0x200 beats same-cycle prediction -> 0x204
    '{8'd10, 1'b1, 32'h100, 1'b1, 32'h200, 1'b0, 32'h0,   1'b1, 32'h204, 1'b0, 1'b1},
    // R9: 0x200 was not allocated
    '{8'd9,  1'b1, 32'h200, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h208, 1'b0, 1'b0},
    // R9: line for 0x100 untouched
    '{8'd9,  1'b1, 32'h100, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h500, 1'b1, 1'b0},
    // R10/R11: taken mispredict at 0x200 -> 0x900, replaces line 0
    '{8'd10, 1'b0, 32'h0,   1'b1, 32'h200, 1'b1, 32'h900, 1'b1, 32'h900, 1'b0, 1'b1},
    // R11: old group 0x100 now misses
    '{8'd11, 1'b1, 32'h100, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h108, 1'b0, 1'b0},
    // R11/R4: new group hits with weakly taken counter
    '{8'd11, 1'b1, 32'h204, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h900, 1'b1, 1'b0},
    // R2: unaligned fetch 0x10C -> 0x110
    '{8'd2,  1'b1, 32'h10C, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 32'h110, 1'b0, 1'b0},
    // R10: mispredict without rslv_valid is ignored
    '{8'd10, 1'b1, 32'h10C, 1'b0, 32'h200, 1'b1, 32'h900, 1'b1, 32'h110, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [AW-1:0] exp_pc,
                       input logic exp_pred, input logic exp_redir);
    checks++;
    if (next_pc !== exp_pc || pred_taken !== exp_pred || redirect !== exp_redir) begin
      errors++;
      $display("FAIL %s next_pc=%h exp %h pred_taken=%b exp %b redirect=%b exp %b",
               req, next_pc, exp_pc, pred_taken, exp_pred, redirect, exp_redir);
    end
  endtask

  task automatic step(input logic fv, input logic [AW-1:0] fpc, input logic rv,
                      input logic [AW-1:0] rpc, input logic rt,
                      input logic [AW-1:0] rtgt, input logic rm);
    @(negedge clk);
    fetch_valid = fv; fetch_pc = fpc; rslv_valid = rv; rslv_pc = rpc;
    rslv_taken = rt; rslv_target = rtgt; rslv_mispredict = rm;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    fetch_valid = 0; fetch_pc = '0; rslv_valid = 0; rslv_pc = '0;
    rslv_taken = 0; rslv_target = '0; rslv_mispredict = 0;
    repeat (3) @(posedge clk);
    #2;
    check("R1", 32'h0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].fv, VEC[i].fpc, VEC[i].rv, VEC[i].rpc, VEC[i].rt, VEC[i].rtgt, VEC[i].rm);
      check($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].enext, VEC[i].epred, VEC[i].eredir);
    end

    // R1: reset with a live fetch on a cached group clears outputs and lines
    @(negedge clk);
    rst = 1'b1;
    step(1'b1, 32'h204, 1'b0, '0, 1'b0, '0, 1'b0);
    check("R1 during reset", 32'h0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    step(1'b1, 32'h204, 1'b0, '0, 1'b0, '0, 1'b0);
    check("R1 lines invalid", 32'h208, 1'b0, 1'b0);

    // R6: saturate at strongly taken on group 0x300
    step(1'b0, '0, 1'b1, 32'h300, 1'b1, 32'h700, 1'b0);  // alloc 10
    step(1'b0, '0, 1'b1, 32'h300, 1'b1, 32'h700, 1'b0);  // 11
    step(1'b0, '0, 1'b1, 32'h300, 1'b1, 32'h700, 1'b0);  // 11 saturated
    check("R12 hold during resolves", 32'h208, 1'b0, 1'b0);
    step(1'b0, '0, 1'b1, 32'h300, 1'b0, '0, 1'b0);       // 10
    step(1'b1, 32'h300, 1'b0, '0, 1'b0, '0, 1'b0);
    check("R6 top saturation", 32'h700, 1'b1, 1'b0);
    step(1'b0, '0, 1'b1, 32'h304, 1'b0, '0, 1'b0);       // 01
    step(1'b1, 32'h300, 1'b0, '0, 1'b0, '0, 1'b0);
    check("R7 reversal after two", 32'h308, 1'b0, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule